// File: doc/BRIEF.md
# Maskable Interrupt Request Generator

This block gathers one-cycle event pulses from the rest of a design into a register of sticky status bits. A second register holds one mask bit for each status bit. Together they drive a single active-low request line toward the host. The line is low while any status bit is set and its mask bit is clear. The host reads both registers through a small register port. It clears status bits by writing ones to them, and it rewrites the mask register as a whole.

A three-state sequencer drives the request line. The states are `ST_IDLE` (line high, nothing enabled pending), `ST_ASSERT` (line low) and `ST_GAP` (line high for one cycle while enabled bits are still pending). The transitions are:

- `ST_IDLE`→`ST_ASSERT` when enabled pending bits appear.
- `ST_ASSERT`→`ST_IDLE` when a clear or a mask change leaves nothing enabled pending.
- `ST_ASSERT`→`ST_GAP` when a host write removes some enabled pending bits but others remain.
- `ST_GAP`→`ST_ASSERT` when anything enabled is still pending.
- `ST_GAP`→`ST_IDLE` when nothing enabled is pending.

The gap state exists so that an edge-sensitive interrupt controller sees a fresh falling edge after it has serviced only part of the pending work.

Top module: `irq_req_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows all status bits 0, all mask bits 1 (every source blocked) and `irq_n` high.
- R2: An `evt` bit high at a clock edge sets the matching status bit from that edge on. The bit stays set until it is cleared.
- R3: A write with `reg_sel`=0 clears every status bit whose `reg_wdata` bit is 1. Status bits whose `reg_wdata` bit is 0 keep their value.
- R4: `irq_n` goes low at the edge after which some status bit is set with its mask bit 0. A mask bit of 1 blocks its status bit from the line.
- R5: A host write that removes every enabled pending bit returns `irq_n` high at that edge. The line then stays high, with no low pulse, until a new enabled bit appears.
- R6: A status write that removes some but not all enabled pending bits while `irq_n` is low drives `irq_n` high for exactly one cycle. The line is low again in the following cycle.
- R7: If an `evt` bit and a clearing write to the same bit fall in the same cycle, the event wins and the bit stays set.
- R8: A write with `reg_sel`=1 loads `reg_wdata` into the mask register. The new mask acts on `irq_n` from the next edge, and a mask write never causes a one-cycle gap.
- R9: `reg_rdata` shows the status register when `reg_sel`=0 and the mask register when `reg_sel`=1, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NUM_SRC | Event pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata | input | NUM_SRC | Write data (ones clear status bits; mask value for the mask register) |
| reg_rdata | output | NUM_SRC | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can fall on the same edge: an event setting a bit, and a host write clearing that same bit. A partial clear can also coincide with a fresh event elsewhere. The bench provokes the first directly by pulsing one event while writing a one to the same position. A scoreboard item then expects the bit to read back as set and the line to stay low, with no gap, because nothing was actually removed. A long mixed stretch of random events, clears and mask writes keeps these collisions coming. A reference model built from the requirements judges each cycle's line level and read data.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_GAP    = 2'd2
    } req_state_e;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_MASK   = 1'b1;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_en,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] status_d,
    output logic [NUM_SRC-1:0] removed
);
    // Per-bit sticky cell: event has priority over a clear in the same cycle
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic clr_i;
        always_comb begin
            clr_i       = clr_en && clr_bits[i];
            status_d[i] = evt[i] || (status_q[i] && !clr_i);
            removed[i]  = status_q[i] && clr_i && !evt[i];
        end
        always_ff @(posedge clk) begin
            if (rst) status_q[i] <= 1'b0;
            else     status_q[i] <= status_d[i];
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_en,
    input  logic [NUM_SRC-1:0] ld_val,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] mask_d
);
    always_comb begin
        mask_d = ld_en ? ld_val : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pend_next,
    input  logic part_removed,
    output logic irq_n
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = pend_next ? ST_ASSERT : ST_IDLE;
            ST_ASSERT: begin
                if (!pend_next)        state_d = ST_IDLE;
                else if (part_removed) state_d = ST_GAP;
                else                   state_d = ST_ASSERT;
            end
            ST_GAP:    state_d = pend_next ? ST_ASSERT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != ST_ASSERT);
    end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] status_q, status_d, removed;
    logic [NUM_SRC-1:0] mask_q, mask_d;
    logic               wr_status, wr_mask;
    logic               pend_next, part_removed;

    always_comb begin
        wr_status = reg_wr && (reg_sel == SEL_STATUS);
        wr_mask   = reg_wr && (reg_sel == SEL_MASK);
    end

    irq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_en   (wr_status),
        .clr_bits (reg_wdata),
        .status_q (status_q),
        .status_d (status_d),
        .removed  (removed)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (wr_mask),
        .ld_val (reg_wdata),
        .mask_q (mask_q),
        .mask_d (mask_d)
    );

    always_comb begin
        pend_next    = |(status_d & ~mask_d);
        part_removed = |(removed & ~mask_q);
    end

    irq_req_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pend_next    (pend_next),
        .part_removed (part_removed),
        .irq_n        (irq_n)
    );

    always_comb begin
        reg_rdata = (reg_sel == SEL_MASK) ? mask_q : status_q;
    end
endmodule

// File: rtl/irq_req_gen_chk.sv
module irq_req_gen_chk #(
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt,
    input logic               reg_wr,
    input logic               reg_sel,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (irq_n && (status_q == '0) && (mask_q == '1)));

    a_r2_event_sticks: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

    a_r3_ones_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=> ((status_q & $past(reg_wdata & ~evt)) == '0));

    a_r3_zeros_keep: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=>
            ((status_q & $past(~reg_wdata & ~evt)) == $past(status_q & ~reg_wdata & ~evt)));

    a_r4_low_needs_pending: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (|(status_q & ~mask_q)));

    a_r6_gap_follows_clear: assert property (@(posedge clk) disable iff (rst)
        (irq_n && (|(status_q & ~mask_q))) |-> $past(reg_wr && !reg_sel));

    a_r6_gap_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (irq_n && (|(status_q & ~mask_q)) && !reg_wr) |=> !irq_n);

    a_r8_mask_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && reg_wr && reg_sel && (|(status_q & ~reg_wdata))) |=> !irq_n);
endmodule

bind irq_req_gen irq_req_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .irq_n     (irq_n),
    .status_q  (status_q),
    .mask_q    (mask_q)
);

// File: tb/irq_req_gen_bench.sv
module irq_req_gen_bench;
    localparam int N = 16;

    typedef struct {
        string       tag;
        logic        exp_irq;
        logic [N-1:0] exp_rd;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt = '0;
    logic         reg_wr = 1'b0;
    logic         reg_sel = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t sb[$];

    // model state
    logic [N-1:0] m_st = '0;
    logic [N-1:0] m_mk = '1;
    int           m_fsm = 0; // 0 idle, 1 low, 2 gap

    always #4 clk = ~clk;

    irq_req_gen #(.NUM_SRC(N)) u_irq_req_gen (
        .clk(clk), .rst(rst), .evt(evt), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic step(input string tag, input logic r, input logic [N-1:0] e,
                        input logic w, input logic s, input logic [N-1:0] d);
        logic [N-1:0] clr, st_n, mk_n, gone;
        logic pend_n;
        item_t it;
        @(negedge clk);
        rst = r; evt = e; reg_wr = w; reg_sel = s; reg_wdata = d;
        clr  = (w && !s) ? d : '0;
        gone = m_st & clr & ~e & ~m_mk;
        st_n = (m_st & ~clr) | e;
        mk_n = (w && s) ? d : m_mk;
        pend_n = |(st_n & ~mk_n);
        if (r) begin
            st_n = '0; mk_n = '1; m_fsm = 0;
        end else if (m_fsm == 1) begin
            m_fsm = !pend_n ? 0 : ((|gone) ? 2 : 1);
        end else begin
            m_fsm = pend_n ? 1 : 0;
        end
        m_st = st_n; m_mk = mk_n;
        it.tag = tag;
        it.exp_irq = (m_fsm != 1);
        it.exp_rd = s ? m_mk : m_st;
        sb.push_back(it);
    endtask

    task automatic idle(input string tag, input logic s);
        step(tag, 1'b0, '0, 1'b0, s, '0);
    endtask

    // monitor: one item per edge, sampled after the outputs settle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (irq_n !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s irq_n actual %0b expected %0b", it.tag, irq_n, it.exp_irq);
                end
                checks++;
                if (reg_rdata !== it.exp_rd) begin
                    errors++;
                    $display("FAIL %s reg_rdata actual %h expected %h", it.tag, reg_rdata, it.exp_rd);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step("R1", 1'b1, '0, 1'b0, 1'b0, '0);
        step("R1", 1'b1, 16'h00F0, 1'b0, 1'b1, '0);
        idle("R1 R9", 1'b1);
        idle("R1 R9", 1'b0);
        // masked event stays off the line
        step("R4 masked", 1'b0, 16'h0080, 1'b0, 1'b0, '0);
        idle("R4 masked", 1'b0);
        // unmask all: line drops on next edge
        step("R8 unmask", 1'b0, '0, 1'b1, 1'b1, 16'h0000);
        idle("R8 R9", 1'b0);
        // full clear of bit 7
        step("R5 full clear", 1'b0, '0, 1'b1, 1'b0, 16'h0080);
        idle("R5 no pulse", 1'b0);
        idle("R5 no pulse", 1'b0);
        // events set bits
        step("R2 R4", 1'b0, 16'h0008, 1'b0, 1'b0, '0);
        step("R2", 1'b0, 16'h0220, 1'b0, 1'b0, '0);
        idle("R2 sticky", 1'b0);
        // write of zeros changes nothing
        step("R3 zeros", 1'b0, '0, 1'b1, 1'b0, 16'h0000);
        // partial clear: one-cycle gap
        step("R6 gap", 1'b0, '0, 1'b1, 1'b0, 16'h0008);
        idle("R6 relow", 1'b0);
        idle("R6 relow", 1'b0);
        // full clear of the rest: no gap
        step("R5 R3 full clear", 1'b0, '0, 1'b1, 1'b0, 16'h0220);
        idle("R5 stays high", 1'b0);
        // event vs clear on same bit
        step("R2", 1'b0, 16'h0002, 1'b0, 1'b0, '0);
        step("R7 collide", 1'b0, 16'h0002, 1'b1, 1'b0, 16'h0002);
        idle("R7 kept", 1'b0);
        // mask the only pending bit: line rises, no pulse
        step("R8 mask", 1'b0, '0, 1'b1, 1'b1, 16'h0002);
        idle("R8 masked high", 1'b0);
        step("R8 unmask", 1'b0, '0, 1'b1, 1'b1, 16'h0000);
        idle("R8 low", 1'b0);
        // mask one of two pending bits: no gap
        step("R2", 1'b0, 16'h0100, 1'b0, 1'b0, '0);
        step("R8 partial mask", 1'b0, '0, 1'b1, 1'b1, 16'h0100);
        idle("R8 no gap", 1'b0);
        // partial clear colliding with a new event elsewhere
        step("R6 R7 mix", 1'b0, 16'h4000, 1'b1, 1'b0, 16'h0002);
        idle("R6 relow", 1'b0);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] e, d;
            int op;
            e = ($urandom_range(0, 3) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
            d = N'($urandom);
            op = $urandom_range(0, 9);
            if (op < 4)       step("MIX clear", 1'b0, e, 1'b1, 1'b0, d & N'($urandom));
            else if (op == 4) step("MIX mask", 1'b0, e, 1'b1, 1'b1, d);
            else              step("MIX idle", 1'b0, e, 1'b0, op[0], '0);
        end
        step("R1 late", 1'b1, '0, 1'b0, 1'b0, '0);
        idle("R1 late", 1'b1);
        idle("R1 late", 1'b0);
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule